// File: doc/BRIEF.md
# Self-Synchronising Bit Error Ratio Checker

This block sits on the receive side of a serial link test. It takes one received bit per valid cycle and generates its own copy of the selected test pattern. It compares the two streams and counts the mismatches, which is the Hamming distance between them. It also counts how many bits it has compared. Software divides the first count by the second to get the error ratio, so 3 errors in 10 compared bits gives 0.3.

For each pattern, the block first synchronises its generator to the phase of the incoming stream. While unlocked, it feeds received bits into its own history. It declares lock once enough consecutive predictions have been correct, and from then on its generator runs free. Counting happens only while the block is locked.

If errors pile up inside one observation window, lock drops and synchronisation starts again. The compared-bit index of each of the first few errors is kept in a small log that can be read by address. A snapshot request copies both counters together, so a pair read while the test runs is consistent.

Top module: `ber_checker`

## Requirements
- R1: `pat_sel` picks the expected pattern, where b[n] is the newest bit. Encoding 0 gives b[n] = b[n-6] xor b[n-7], a 127-bit pseudo-random sequence. Encoding 1 gives b[n] = b[n-14] xor b[n-15], a 32767-bit sequence. Encoding 2 gives all ones. Encoding 3 gives b[n] = not b[n-1], alternating bits. History that precedes a clear reads as zero.
- R2: While unlocked, each valid received bit enters the history. Lock is declared on the `LOCK_RUN`-th consecutive valid bit (default 64) that matches the prediction, and the prediction made for that bit is the test. Neither counter changes while the block is unlocked.
- R3: While locked, the history advances with the generator's own predicted bit. Each valid bit adds one to `bit_count`, and each mismatching valid bit also adds one to `err_count`. Both outputs update at the clock edge that samples the bit.
- R4: A cycle with `rx_valid` low changes no counter, no lock state, no log entry and no history, whatever `rx_bit` holds.
- R5: Once locked, compared bits fall into windows of `WIN_LEN` bits (default 1024). A window starts at lock and restarts after every `WIN_LEN` compared bits. The error that takes the count in the current window above `WIN_ERR_MAX` (default 8) is counted and logged, and lock then drops at that same edge.
- R6: Each of the first `LOG_DEPTH` (default 16) counted errors stores, in arrival order, the `bit_count` value held before that bit. Entry k appears combinationally on `log_data` when `log_addr` is k. `log_count` gives the number of entries filled, and unfilled entries read zero.
- R7: A counted error that arrives with the log already full sets `log_ovf` and leaves every stored entry unchanged.
- R8: `snap_req` copies the `err_count` and `bit_count` values held in that cycle, before any update made at the same edge, into `snap_err` and `snap_bits` together.
- R9: `err_count` and `bit_count` stop at their all-ones value and never wrap.
- R10: `rst`, or a `clr` pulse, returns every counter, snapshot, log entry, history bit and the lock state to zero. A cycle with `clr` high ignores `rx_valid` and `snap_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Start/clear pulse for a new test |
| pat_sel | input | 2 | Expected pattern select (R1 encoding) |
| rx_bit | input | 1 | Received bit |
| rx_valid | input | 1 | `rx_bit` holds a bit in this cycle |
| snap_req | input | 1 | Copy both counters to the snapshot outputs |
| locked | output | 1 | Generator is aligned and counting |
| err_count | output | CNT_W | Live error count |
| bit_count | output | CNT_W | Live compared-bit count |
| snap_err | output | CNT_W | Error count at the last snapshot |
| snap_bits | output | CNT_W | Compared-bit count at the last snapshot |
| log_count | output | clog2(LOG_DEPTH+1) | Log entries filled |
| log_ovf | output | 1 | An error arrived while the log was full |
| log_addr | input | clog2(LOG_DEPTH) | Log read address |
| log_data | output | CNT_W | Log entry at `log_addr` |

## Verification
The bench targets the lock boundary first. A design that locks one bit early or late, or that counts bits during acquisition, drifts from the model on the very first compared bit. Bursts are placed so that the ninth error in a window arrives at a known bit. Losing lock one error too early or too late then shows up as a wrong `locked` value and wrong totals afterwards.

The log is filled past its depth with errors that arrive after `bit_count` has already saturated. An overwrite of old entries, or an index taken after the increment, changes `log_data`. Random gaps with garbage on `rx_bit` catch any path that lets an invalid cycle shift the history. Repeated bursts drive both counters into saturation, where a wrap to zero would be obvious.

// File: rtl/ber_checker.sv
module ber_checker #(
  parameter int CNT_W       = 32,
  parameter int LOG_DEPTH   = 16,
  parameter int LOCK_RUN    = 64,
  parameter int WIN_LEN     = 1024,
  parameter int WIN_ERR_MAX = 8,
  localparam int LA_W = $clog2(LOG_DEPTH),
  localparam int LC_W = $clog2(LOG_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [1:0]       pat_sel,
  input  logic             rx_bit,
  input  logic             rx_valid,
  input  logic             snap_req,
  output logic             locked,
  output logic [CNT_W-1:0] err_count,
  output logic [CNT_W-1:0] bit_count,
  output logic [CNT_W-1:0] snap_err,
  output logic [CNT_W-1:0] snap_bits,
  output logic [LC_W-1:0]  log_count,
  output logic             log_ovf,
  input  logic [LA_W-1:0]  log_addr,
  output logic [CNT_W-1:0] log_data
);
  localparam int RUN_W = $clog2(LOCK_RUN);
  localparam int WIN_W = $clog2(WIN_LEN);
  localparam int WE_W  = $clog2(WIN_ERR_MAX + 1);

  logic [14:0]      hist;
  logic [RUN_W-1:0] run;
  logic [WIN_W-1:0] win_pos;
  logic [WE_W-1:0]  win_err;
  logic [CNT_W-1:0] log_mem [LOG_DEPTH];
  logic             exp_bit;

  always_comb
    case (pat_sel)
      2'd0:    exp_bit = hist[6] ^ hist[5];
      2'd1:    exp_bit = hist[14] ^ hist[13];
      2'd2:    exp_bit = 1'b1;
      default: exp_bit = ~hist[0];
    endcase

  wire miss     = rx_bit ^ exp_bit;
  wire take     = rx_valid && !clr;
  wire cnt_en   = take && locked;
  wire win_trip = cnt_en && miss && (win_err == WE_W'(WIN_ERR_MAX));
  wire win_end  = win_pos == WIN_W'(WIN_LEN - 1);
  wire log_full = log_count == LC_W'(LOG_DEPTH);

  assign log_data = log_mem[log_addr];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hist      <= '0;
      run       <= '0;
      locked    <= 1'b0;
      win_pos   <= '0;
      win_err   <= '0;
      err_count <= '0;
      bit_count <= '0;
      snap_err  <= '0;
      snap_bits <= '0;
      log_count <= '0;
      log_ovf   <= 1'b0;
      for (int i = 0; i < LOG_DEPTH; i++) log_mem[i] <= '0;
    end else begin
      if (snap_req) begin
        snap_err  <= err_count;
        snap_bits <= bit_count;
      end
      if (take) hist <= {hist[13:0], locked ? exp_bit : rx_bit};
      if (take && !locked) begin
        if (miss) run <= '0;
        else if (run == RUN_W'(LOCK_RUN - 1)) begin
          locked  <= 1'b1;
          run     <= '0;
          win_pos <= '0;
          win_err <= '0;
        end else run <= run + 1'b1;
      end
      if (cnt_en) begin
        if (!(&bit_count)) bit_count <= bit_count + 1'b1;
        if (miss) begin
          if (!(&err_count)) err_count <= err_count + 1'b1;
          if (!log_full) begin
            log_mem[log_count[LA_W-1:0]] <= bit_count;
            log_count <= log_count + 1'b1;
          end else log_ovf <= 1'b1;
        end
        win_pos <= win_end ? '0 : win_pos + 1'b1;
        win_err <= win_end ? '0 : win_err + WE_W'(miss);
        if (win_trip) begin
          locked <= 1'b0;
          run    <= '0;
        end
      end
    end
  end

  a_r2_no_count_unlocked: assert property (@(posedge clk) disable iff (rst)
    (!locked && !clr) |=> $stable(bit_count) && $stable(err_count));
  a_r4_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!rx_valid && !clr) |=> $stable(bit_count) && $stable(err_count) && $stable(locked)
                            && $stable(log_count));
  a_r3_err_within_bits: assert property (@(posedge clk) disable iff (rst)
    err_count <= bit_count);
  a_r7_ovf_only_full: assert property (@(posedge clk) disable iff (rst)
    log_ovf |-> log_count == LC_W'(LOG_DEPTH));
  a_r9_err_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (!clr && (&err_count)) |=> &err_count);
  a_r9_bits_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (!clr && (&bit_count)) |=> &bit_count);
endmodule

// File: tb/ber_checker_tb_top.sv
module ber_checker_tb_top;
  localparam int CNT_W = 10, LOG_DEPTH = 16, LOCK_RUN = 64, WIN_LEN = 1024, WIN_ERR_MAX = 8;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 0, rst = 1, clr = 0, rx_bit = 0, rx_valid = 0, snap_req = 0, locked, log_ovf;
  logic [1:0] pat_sel = 0;
  logic [CNT_W-1:0] err_count, bit_count, snap_err, snap_bits, log_data;
  logic [4:0] log_count;
  logic [3:0] log_addr = 0;

  ber_checker #(.CNT_W(CNT_W), .LOG_DEPTH(LOG_DEPTH), .LOCK_RUN(LOCK_RUN),
                .WIN_LEN(WIN_LEN), .WIN_ERR_MAX(WIN_ERR_MAX)) dut_i (
    .clk(clk), .rst(rst), .clr(clr), .pat_sel(pat_sel), .rx_bit(rx_bit),
    .rx_valid(rx_valid), .snap_req(snap_req), .locked(locked), .err_count(err_count),
    .bit_count(bit_count), .snap_err(snap_err), .snap_bits(snap_bits),
    .log_count(log_count), .log_ovf(log_ovf), .log_addr(log_addr), .log_data(log_data));

  always #2 clk = ~clk;

  int vecs = 0, bad = 0;
  bit done = 0;
  string tag = "R10";

  // reference model
  bit mh[$];
  int mlog[$];
  int m_locked = 0, m_run = 0, m_bits = 0, m_errs = 0, m_wpos = 0, m_werr = 0;
  int m_snb = 0, m_sne = 0, m_ovf = 0;

  function automatic bit hb(int k);
    return (k < mh.size()) ? mh[k] : 1'b0;
  endfunction

  function automatic bit expv();
    case (pat_sel)
      2'd0: return hb(6) ^ hb(5);
      2'd1: return hb(14) ^ hb(13);
      2'd2: return 1'b1;
      default: return !hb(0);
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst || clr) begin
      mh = {}; mlog = {};
      m_locked = 0; m_run = 0; m_bits = 0; m_errs = 0; m_wpos = 0; m_werr = 0;
      m_snb = 0; m_sne = 0; m_ovf = 0;
    end else begin
      if (snap_req) begin m_snb = m_bits; m_sne = m_errs; end
      if (rx_valid) begin
        bit e, miss;
        e = expv();
        miss = (rx_bit != e);
        if (m_locked == 0) begin
          mh.push_front(rx_bit);
          if (miss) m_run = 0;
          else if (m_run == LOCK_RUN - 1) begin
            m_locked = 1; m_run = 0; m_wpos = 0; m_werr = 0;
          end else m_run++;
        end else begin
          mh.push_front(e);
          if (miss) begin
            if (mlog.size() < LOG_DEPTH) mlog.push_back(m_bits); else m_ovf = 1;
            if (m_errs < CMAX) m_errs++;
          end
          if (m_bits < CMAX) m_bits++;
          if (miss && m_werr == WIN_ERR_MAX) begin m_locked = 0; m_run = 0; end
          if (m_wpos == WIN_LEN - 1) begin m_wpos = 0; m_werr = 0; end
          else begin m_wpos++; m_werr += int'(miss); end
        end
        if (mh.size() > 15) void'(mh.pop_back());
      end
    end
  end

  task automatic chk(string what, int got, int exp);
    vecs++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!rst) begin
      int a;
      a = int'(log_addr);
      chk("locked", int'(locked), m_locked);
      chk("bit_count", int'(bit_count), m_bits);
      chk("err_count", int'(err_count), m_errs);
      chk("snap_bits", int'(snap_bits), m_snb);
      chk("snap_err", int'(snap_err), m_sne);
      chk("log_count", int'(log_count), mlog.size());
      chk("log_ovf", int'(log_ovf), m_ovf);
      chk("log_data", int'(log_data), (a < mlog.size()) ? mlog[a] : 0);
    end
  end

  // transmit-side pattern source
  bit th[$];
  function automatic void seed_tx();
    th = {};
    for (int i = 0; i < 15; i++) th.push_back(i == 3 ? 1'b1 : 1'($urandom));
  endfunction
  function automatic bit tx_next();
    bit nb;
    case (pat_sel)
      2'd0: nb = th[5] ^ th[6];
      2'd1: nb = th[13] ^ th[14];
      2'd2: nb = 1'b1;
      default: nb = !th[0];
    endcase
    th.push_front(nb);
    void'(th.pop_back());
    return nb;
  endfunction

  task automatic run_bits(int n, int err_gap, int gap_pct, int snap_pct);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      snap_req = (($urandom % 100) < snap_pct);
      log_addr = 4'($urandom);
      if (($urandom % 100) < gap_pct) begin
        rx_valid = 0; rx_bit = 1'($urandom);
        k--;
      end else begin
        rx_valid = 1;
        rx_bit = tx_next() ^ ((err_gap > 0) && (k % err_gap == err_gap - 1));
      end
    end
    @(negedge clk);
    rx_valid = 0; snap_req = 0;
  endtask

  task automatic do_clr(logic [1:0] sel);
    @(negedge clk);
    clr = 1; pat_sel = sel; rx_valid = 0; snap_req = 1;
    @(negedge clk);
    clr = 0; snap_req = 0;
    seed_tx();
  endtask

  initial begin
    seed_tx();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    tag = "R10";
    chk("reset locked", int'(locked), 0);
    chk("reset err_count", int'(err_count), 0);
    tag = "R1"; run_bits(200, 0, 0, 0);
    chk("PRBS7 lock R2", int'(locked), 1);
    tag = "R6"; run_bits(2300, 130, 0, 0);
    tag = "R7"; chk("log full", int'(log_count), 16);
    tag = "R8"; run_bits(400, 97, 0, 30);
    tag = "R4"; run_bits(500, 83, 40, 10);
    tag = "R5"; run_bits(300, 0, 0, 0); run_bits(20, 2, 0, 0);
    chk("lock dropped", int'(locked), 0);
    tag = "R10"; do_clr(2'd1);
    chk("clear bit_count", int'(bit_count), 0);
    chk("clear log_count", int'(log_count), 0);
    tag = "R2"; run_bits(70, 0, 0, 0);
    chk("not yet locked", int'(locked), 0);
    tag = "R1"; run_bits(400, 150, 10, 5);
    do_clr(2'd2); run_bits(300, 50, 10, 5);
    do_clr(2'd3); run_bits(300, 60, 10, 5);
    tag = "R9"; do_clr(2'd0);
    for (int it = 0; it < 300 && m_errs < CMAX; it++) begin
      run_bits(120, 0, 0, 2); run_bits(20, 2, 0, 2);
    end
    run_bits(120, 0, 0, 0); run_bits(20, 2, 0, 0);
    chk("err saturated", int'(err_count), CMAX);
    chk("bits saturated", int'(bit_count), CMAX);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog %s: got hung run expected completion", tag);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule